// File: doc/BRIEF.md
# Trapping Signed/Unsigned Adder-Subtractor

This block is a two's-complement add/subtract unit that serves two operation classes on one datapath. The non-trapping class wraps silently modulo 2^W. The trapping class raises an exception when the signed result cannot be represented. Subtraction uses the same ripple-carry chain as addition: the second operand is bit-inverted and a carry of one is fed in. Overflow follows the sign rules on the operand signs and the result sign. The sum, carry-out, overflow flag and exception pulse are all combinational.

When a valid trapping operation overflows, the block drives the fixed handler address on `redirect_pc` in that same cycle. At the next rising clock edge it copies the program counter of the faulting operation into its exception-PC register. The register is readable at all times, so the handler can return from it, and it keeps its value until the next exception.

The operand interface has a `op_valid` qualifier and no ready. The block accepts an operation in every cycle and never applies back-pressure. An upstream stage that cannot hold its data needs no stall path, because the block has no storage on the data path.

Top module: `trap_addsub`

## Requirements
- R1: With `op_sub`=0, `sum_out` = (`opnd_a` + `opnd_b`) mod 2^32 and `carry_out` is bit 32 of the unsigned sum.
- R2: With `op_sub`=1, `sum_out` = (`opnd_a` − `opnd_b`) mod 2^32 and `carry_out` is 1 exactly when `opnd_a` ≥ `opnd_b` as unsigned numbers, meaning no borrow.
- R3: In addition, `ovf_flag` is 1 when both operands have sign bit 0 and the result has sign bit 1, or when both have sign bit 1 and the result has sign bit 0. Operands of opposite sign never set it.
- R4: In subtraction, `ovf_flag` is 1 when a non-negative `opnd_a` minus a negative `opnd_b` gives sign bit 1, or when a negative `opnd_a` minus a non-negative `opnd_b` gives sign bit 0. Operands of equal sign never set it.
- R5: `ovf_flag` is computed whatever the values of `op_valid` and `op_trap`.
- R6: `trap_pulse` is 1 only when `op_valid`, `op_trap` and `ovf_flag` are all 1. The non-trapping class (`op_trap`=0) never raises it.
- R7: At a rising clock edge where `trap_pulse` is 1, `epc_q` takes the value of `cur_pc`, and it is visible after that edge.
- R8: `epc_q` resets to 0 and otherwise holds its value through every edge where `trap_pulse` is 0.
- R9: `redirect_pc` equals the HANDLER_PC parameter, 32'h8000_0180 by default, while `trap_pulse` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_trap | input | 1 | 1 = trapping signed class, 0 = wrapping class |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| cur_pc | input | 32 | Program counter of the current operation |
| sum_out | output | 32 | Result |
| carry_out | output | 1 | Carry out of the top bit |
| ovf_flag | output | 1 | Signed overflow of this result |
| trap_pulse | output | 1 | Exception raised this cycle |
| redirect_pc | output | 32 | Handler address during an exception, else 0 |
| epc_q | output | 32 | Captured exception PC |

## Verification
`sum_out`, `carry_out`, `ovf_flag`, `trap_pulse` and `redirect_pc` are due in the same cycle the operands are applied. The bench drives inputs at the falling edge and compares these outputs a fraction of a period later, before the next rising edge. `epc_q` is due one rising edge after a trapping overflow. The reference model therefore moves its expected EPC forward only after that edge and compares it at the following falling edge, before new operands are driven. Directed vectors cover each sign case of both overflow rules, the carry and borrow limits, and exceptions suppressed by `op_valid` or `op_trap`. A long random run follows.

// File: rtl/trap_addsub_pkg.sv
package trap_addsub_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] DEFAULT_HANDLER = 32'h8000_0180;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_kind_e;

  typedef struct packed {
    logic sign_a;
    logic sign_b;
    logic sign_r;
  } sign_triplet_t;
endpackage

// File: rtl/full_adder_cell.sv
module full_adder_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half_x;
  assign half_x = a_i ^ b_i;
  assign s_o    = half_x ^ c_i;
  assign c_o    = (a_i & b_i) | (half_x & c_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain
  import trap_addsub_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_kind_e     kind_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int unsigned CHAIN_LEN = W + 1;

  logic [W-1:0]         b_eff;
  logic [CHAIN_LEN-1:0] cy;

  // the subtract select inverts the second operand and seeds the carry with one
  assign cy[0] = (kind_i == OP_SUB);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i] = b_i[i] ^ (kind_i == OP_SUB);
    full_adder_cell u_fa (
      .a_i (a_i[i]),
      .b_i (b_eff[i]),
      .c_i (cy[i]),
      .s_o (sum_o[i]),
      .c_o (cy[i+1])
    );
  end

  assign carry_o = cy[W];

  // R1 / R2: the bit chain agrees with whole-word arithmetic
  always_comb begin
    if (!$isunknown({a_i, b_i, kind_i})) begin
      if (kind_i == OP_ADD)
        a_chain_add_r1: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}));
      else
        a_chain_sub_r2: assert (sum_o == (a_i - b_i) && carry_o == (a_i >= b_i));
    end
  end
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect
  import trap_addsub_pkg::*;
(
  input  sign_triplet_t signs_i,
  input  op_kind_e      kind_i,
  output logic          ovf_o
);
  logic add_pos_wrap, add_neg_wrap, sub_pos_wrap, sub_neg_wrap;

  always_comb begin
    add_pos_wrap = !signs_i.sign_a && !signs_i.sign_b &&  signs_i.sign_r;
    add_neg_wrap =  signs_i.sign_a &&  signs_i.sign_b && !signs_i.sign_r;
    sub_pos_wrap = !signs_i.sign_a &&  signs_i.sign_b &&  signs_i.sign_r;
    sub_neg_wrap =  signs_i.sign_a && !signs_i.sign_b && !signs_i.sign_r;
    unique case (kind_i)
      OP_ADD:  ovf_o = add_pos_wrap || add_neg_wrap;
      OP_SUB:  ovf_o = sub_pos_wrap || sub_neg_wrap;
      default: ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/epc_capture.sv
module epc_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] epc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_o <= '0;
    else if (take_i) epc_o <= pc_i;
  end

  p_epc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> epc_o == $past(pc_i));

  p_epc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(epc_o));
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
  import trap_addsub_pkg::*;
#(
  parameter int unsigned W          = DATA_W,
  parameter logic [W-1:0] HANDLER_PC = DEFAULT_HANDLER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_sub,
  input  logic         op_trap,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] cur_pc,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         ovf_flag,
  output logic         trap_pulse,
  output logic [W-1:0] redirect_pc,
  output logic [W-1:0] epc_q
);
  localparam int unsigned MSB = W - 1;

  op_kind_e      kind;
  sign_triplet_t signs;

  assign kind = op_sub ? OP_SUB : OP_ADD;

  ripple_chain #(.W(W)) u_chain (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .kind_i  (kind),
    .sum_o   (sum_out),
    .carry_o (carry_out)
  );

  assign signs = '{sign_a: opnd_a[MSB], sign_b: opnd_b[MSB], sign_r: sum_out[MSB]};

  ovf_detect u_ovf (
    .signs_i (signs),
    .kind_i  (kind),
    .ovf_o   (ovf_flag)
  );

  assign trap_pulse  = op_valid && op_trap && ovf_flag;
  assign redirect_pc = trap_pulse ? HANDLER_PC : '0;

  epc_capture #(.W(W)) u_epc (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (trap_pulse),
    .pc_i   (cur_pc),
    .epc_o  (epc_q)
  );

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_sub && (opnd_a[MSB] != opnd_b[MSB])) |-> !ovf_flag);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sub && (opnd_a[MSB] == opnd_b[MSB])) |-> !ovf_flag);

  p_quiet_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_trap || !op_valid) |-> !trap_pulse);

  p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> redirect_pc == HANDLER_PC);
endmodule

// File: tb/trap_addsub_bench.sv
`timescale 1ns/100ps
module trap_addsub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_sub = 1'b0, op_trap = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, cur_pc = '0;
  logic [31:0] sum_out, redirect_pc, epc_q;
  logic        carry_out, ovf_flag, trap_pulse;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] mdl_epc = '0;
  logic [31:0] mdl_epc_next = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_addsub u_trap_addsub (
    .clk, .rst_n, .op_valid, .op_sub, .op_trap, .opnd_a, .opnd_b, .cur_pc,
    .sum_out, .carry_out, .ovf_flag, .trap_pulse, .redirect_pc, .epc_q
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (a=%h b=%h sub=%0b trap=%0b vld=%0b)",
               req, act, exp, opnd_a, opnd_b, op_sub, op_trap, op_valid);
    end
  endtask

  // behavioural reference using wide integers
  task automatic apply(input logic v, input logic s, input logic t,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
    longint sa, sb, sr, ua, ub;
    logic [31:0] e_sum;
    logic e_cy, e_ovf, e_trap;
    @(negedge clk);
    mdl_epc = mdl_epc_next;
    chk("R7/R8 epc", epc_q, mdl_epc);
    op_valid = v; op_sub = s; op_trap = t; opnd_a = a; opnd_b = b; cur_pc = pc;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a);          ub = longint'(b);
    if (!s) begin
      e_sum = 32'(ua + ub); e_cy = (ua + ub) > 64'hFFFF_FFFF; sr = sa + sb;
    end else begin
      e_sum = 32'(ua - ub); e_cy = (ua >= ub); sr = sa - sb;
    end
    e_ovf  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    e_trap = v && t && e_ovf;
    #1;
    chk(s ? "R2 sum" : "R1 sum", sum_out, e_sum);
    chk(s ? "R2 carry" : "R1 carry", carry_out, e_cy);
    chk(s ? "R4 ovf" : "R3 ovf", ovf_flag, e_ovf);
    chk("R6 trap", trap_pulse, e_trap);
    chk("R9 redirect", redirect_pc, e_trap ? 32'h8000_0180 : 32'h0);
    if (e_trap) mdl_epc_next = pc;
  endtask

  initial begin
    #1000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #0.5;
    chk("R8 reset epc", epc_q, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R3 additions
    apply(1, 0, 1, 32'd7, 32'd6, 32'h100);
    apply(1, 0, 1, 32'h7FFF_FFFF, 32'd1, 32'h104);          // R3 pos wrap, trap
    apply(1, 0, 1, 32'h8000_0000, 32'h8000_0000, 32'h108);  // R3 neg wrap, carry
    apply(1, 0, 1, 32'h7FFF_FFFF, 32'h8000_0000, 32'h10C);  // R3 mixed signs
    apply(1, 0, 0, 32'hFFFF_FFFF, 32'd1, 32'h110);          // R1 carry, no ovf
    // R2 / R4 subtractions
    apply(1, 1, 1, 32'd5, 32'd7, 32'h114);                  // R2 borrow
    apply(1, 1, 1, 32'h8000_0000, 32'd1, 32'h118);          // R4 neg minus pos
    apply(1, 1, 1, 32'd0, 32'h8000_0000, 32'h11C);          // R4 pos minus neg
    apply(1, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h120);  // R4 same sign
    apply(1, 1, 1, 32'd9, 32'd9, 32'h124);                  // R2 equal, carry 1
    // R5 / R6 suppression with overflow present
    apply(1, 1, 0, 32'h8000_0000, 32'd1, 32'h128);          // quiet class
    apply(0, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h12C);  // no valid
    apply(1, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h130);  // back-to-back trap
    apply(1, 1, 1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h134);
    apply(1, 0, 0, 32'd1, 32'd2, 32'h138);                  // R8 hold
    for (int i = 0; i < 120; i++)
      apply(1'($urandom), 1'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom);
    apply(0, 0, 0, 32'd0, 32'd0, 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule